// File: doc/BRIEF.md
# Edge-Selectable Counter Capture

This block takes a snapshot of a running 16-bit counter whenever a chosen transition appears on an asynchronous capture pin. The pin first passes through a synchronizer. An edge detector then compares each synchronized sample with the one before it.

Two select inputs choose which transitions count. With both select bits low, only falling transitions are captured. With both high, only rising transitions are captured. When the two bits disagree, every transition is captured.

Each capture writes the counter value into a capture register and sets a sticky flag. The flag stays set until a one-cycle clear pulse arrives. Software or a neighbouring block reads the capture register and the flag directly. It can then compute the time between events by subtracting successive snapshots.

Top module: `edgeCaptureUnit`

## Requirements
- R1: After reset, `capValue` reads 0x0000 and `capFlag` reads 0.
- R2: With `selA`=0 and `selB`=0, a falling transition of `capPin` causes a capture, and a rising transition leaves `capValue` and `capFlag` unchanged.
- R3: With `selA`=1 and `selB`=1, a rising transition of `capPin` causes a capture, and a falling transition leaves `capValue` and `capFlag` unchanged.
- R4: When `selA` and `selB` differ, both rising and falling transitions of `capPin` cause a capture.
- R5: Suppose a new `capPin` level is first sampled at rising clock edge E. Then `capValue` is updated at edge E+2 with the value `countVal` held just before edge E+2.
- R6: A `capPin` level that is held across at least one rising clock edge is seen. This means a pulse of one clock period gives one capture in a single-edge mode and two captures on consecutive cycles in the both-edge mode.
- R7: Every capture sets `capFlag` to 1, and the flag stays at 1 until it is cleared.
- R8: A one-cycle `flagClr` pulse with no capture in the same cycle brings `capFlag` to 0 at the next clock edge. `capValue` is not affected by the clear.
- R9: If a capture and `flagClr` fall on the same clock edge, the capture wins: `capFlag` stays 1 and `capValue` takes the new count.
- R10: While the synchronized pin level is unchanged, `capValue` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| capPin | input | 1 | Asynchronous capture pin; its idle level during reset is low |
| countVal | input | 16 | Current value of the free-running counter |
| selA | input | 1 | Edge select bit A |
| selB | input | 1 | Edge select bit B |
| flagClr | input | 1 | One-cycle pulse that clears the capture flag |
| capValue | output | 16 | Capture register contents |
| capFlag | output | 1 | Sticky capture flag |

## Verification
The assertions assume three things about the inputs:
- `capPin` is held low while reset is active, so the synchronizer comes out of reset at the same level as the pin.
- `selA` and `selB` change only while the pin is quiet, so no edge is judged under a mode that is half-switched.
- `flagClr` starts from a defined level.

The stimulus keeps within these limits:
- It drives every input on the falling clock edge.
- It holds the pin low through reset.
- It changes the mode only after the previous pulse has fully settled.
- It uses pulses of one, two and three whole clock periods, so every level is sampled by at least one rising edge.

// File: rtl/edgeCapturePkg.sv
package edgeCapturePkg;

  typedef enum logic [1:0] {
    MODE_FALL = 2'd0,
    MODE_RISE = 2'd1,
    MODE_BOTH = 2'd2
  } edgeMode_t;

  typedef struct packed {
    logic loadCap;
    logic setFlag;
    logic clrFlag;
  } capStrobes_t;

  function automatic edgeMode_t decodeMode(input logic selA, input logic selB);
    if (selA != selB) return MODE_BOTH;
    else if (selA)    return MODE_RISE;
    else              return MODE_FALL;
  endfunction

endpackage

// File: rtl/pinSync.sv
module pinSync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_LVL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stageQ;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[i] <= RESET_LVL;
          else       stageQ[i] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[i] <= RESET_LVL;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[LAST];
endmodule

// File: rtl/edgeCtrl.sv
module edgeCtrl
  import edgeCapturePkg::*;
#(
  parameter logic RESET_LVL = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncLvl,
  input  logic        selA,
  input  logic        selB,
  input  logic        flagClr,
  output capStrobes_t strobes
);
  logic      prevLvl;
  logic      riseSeen;
  logic      fallSeen;
  logic      capHit;
  edgeMode_t curMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= RESET_LVL;
    else       prevLvl <= syncLvl;
  end

  assign riseSeen = syncLvl & ~prevLvl;
  assign fallSeen = ~syncLvl & prevLvl;
  assign curMode  = decodeMode(selA, selB);

  always_comb begin
    unique case (curMode)
      MODE_RISE: capHit = riseSeen;
      MODE_FALL: capHit = fallSeen;
      MODE_BOTH: capHit = riseSeen | fallSeen;
      default:   capHit = 1'b0;
    endcase
  end

  always_comb begin
    strobes.loadCap = capHit;
    strobes.setFlag = capHit;
    strobes.clrFlag = flagClr & ~capHit;
  end
endmodule

// File: rtl/captureDatapath.sv
module captureDatapath
  import edgeCapturePkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countVal,
  input  capStrobes_t      strobes,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capValue <= '0;
    else if (strobes.loadCap) capValue <= countVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                capFlag <= 1'b0;
    else if (strobes.setFlag) capFlag <= 1'b1;
    else if (strobes.clrFlag) capFlag <= 1'b0;
  end
endmodule

// File: rtl/edgeCaptureUnit.sv
module edgeCaptureUnit
  import edgeCapturePkg::*;
#(
  parameter int   CNT_W       = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capPin,
  input  logic [CNT_W-1:0] countVal,
  input  logic             selA,
  input  logic             selB,
  input  logic             flagClr,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag
);
  logic        syncLvl;
  capStrobes_t strobes;

  pinSync #(.STAGES(SYNC_STAGES), .RESET_LVL(IDLE_LVL)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(capPin), .syncOut(syncLvl)
  );

  edgeCtrl #(.RESET_LVL(IDLE_LVL)) u_ctrl (
    .clk(clk), .rstN(rstN), .syncLvl(syncLvl), .selA(selA), .selB(selB),
    .flagClr(flagClr), .strobes(strobes)
  );

  captureDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .countVal(countVal), .strobes(strobes),
    .capValue(capValue), .capFlag(capFlag)
  );
endmodule

// File: rtl/edgeCaptureChecker.sv
module edgeCaptureChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             selA,
  input logic             selB,
  input logic             flagClr,
  input logic [CNT_W-1:0] countVal,
  input logic             syncLvl,
  input logic             loadCap,
  input logic [CNT_W-1:0] capValue,
  input logic             capFlag
);
  // R5 R7 R9
  load_takes_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadCap) |-> (capFlag && capValue == $past(countVal)));

  // R8
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flagClr) && !$past(loadCap)) |-> !capFlag);

  // R10
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(loadCap) |-> $stable(capValue));

  // R3
  rise_mode_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadCap && selA && selB) |-> syncLvl);

  // R2
  fall_mode_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadCap && !selA && !selB) |-> !syncLvl);
endmodule

bind edgeCaptureUnit edgeCaptureChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .selA(selA), .selB(selB), .flagClr(flagClr),
  .countVal(countVal), .syncLvl(syncLvl), .loadCap(strobes.loadCap),
  .capValue(capValue), .capFlag(capFlag)
);

// File: tb/sim_edgeCaptureUnit.sv
module sim_edgeCaptureUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        capPin = 1'b0;
  logic [15:0] cnt = 16'h0000;
  logic        selA = 1'b0;
  logic        selB = 1'b0;
  logic        flagClr = 1'b0;
  logic [15:0] capValue;
  logic        capFlag;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];
  logic [15:0] lastSeen = 16'h0000;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  edgeCaptureUnit u0 (
    .clk(clk), .rstN(rstN), .capPin(capPin), .countVal(cnt),
    .selA(selA), .selB(selB), .flagClr(flagClr),
    .capValue(capValue), .capFlag(capFlag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every change of capValue must match the next queued expectation.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (capValue !== lastSeen) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected capture", int'(capValue), int'(lastSeen));
        end else begin
          logic [15:0] expV;
          expV = expQ.pop_front();
          check(capValue == expV, "R5 captured count", int'(capValue), int'(expV));
        end
      end
      lastSeen = capValue;
    end
  end

  // Driver: one pulse of given width; queue the expected counts.
  task automatic drivePulse(input int width, input bit capRise, input bit capFall, input string req);
    @(negedge clk);
    capPin = 1'b1;
    if (capRise) expQ.push_back(cnt + 16'd2);
    repeat (width) @(negedge clk);
    capPin = 1'b0;
    if (capFall) expQ.push_back(cnt + 16'd2);
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic setMode(input bit a, input bit b);
    @(negedge clk);
    selA = a;
    selB = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check(capValue == 16'h0000, "R1 capValue after reset", int'(capValue), 0);
    check(capFlag == 1'b0, "R1 capFlag after reset", int'(capFlag), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2 falling only: rising edges queue nothing
    setMode(1'b0, 1'b0);
    for (int w = 1; w <= 3; w++) drivePulse(w, 1'b0, 1'b1, "R2 R6 fall-mode pulse");
    // R7 flag set by capture and sticky
    check(capFlag == 1'b1, "R7 flag after capture", int'(capFlag), 1);
    repeat (5) @(negedge clk);
    check(capFlag == 1'b1, "R7 flag sticky", int'(capFlag), 1);

    // R8 clear without capture; capValue unchanged
    begin
      logic [15:0] held;
      held = capValue;
      flagClr = 1'b1;
      @(negedge clk);
      flagClr = 1'b0;
      check(capFlag == 1'b0, "R8 flag cleared", int'(capFlag), 0);
      check(capValue == held, "R8 capValue kept", int'(capValue), int'(held));
    end

    // R2 rising edge ignored in fall mode: flag stays clear
    @(negedge clk);
    capPin = 1'b1;
    repeat (6) @(negedge clk);
    check(capFlag == 1'b0, "R2 rising ignored", int'(capFlag), 0);
    capPin = 1'b0;
    expQ.push_back(cnt + 16'd2);
    repeat (6) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;

    // R3 rising only
    setMode(1'b1, 1'b1);
    for (int w = 1; w <= 3; w++) drivePulse(w, 1'b1, 1'b0, "R3 R6 rise-mode pulse");
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    @(negedge clk);
    capPin = 1'b1;
    expQ.push_back(cnt + 16'd2);
    repeat (6) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    capPin = 1'b0;
    repeat (6) @(negedge clk);
    check(capFlag == 1'b0, "R3 falling ignored", int'(capFlag), 0);

    // R4 both edges, via each disagreeing setting
    setMode(1'b0, 1'b1);
    for (int w = 1; w <= 3; w++) drivePulse(w, 1'b1, 1'b1, "R4 R6 both-mode pulse");
    setMode(1'b1, 1'b0);
    for (int w = 1; w <= 3; w++) drivePulse(w, 1'b1, 1'b1, "R4 R6 both-mode pulse");

    // R8 clear, then R9 clear colliding with capture
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check(capFlag == 1'b0, "R8 flag cleared in both mode", int'(capFlag), 0);
    capPin = 1'b1;
    expQ.push_back(cnt + 16'd2);
    repeat (2) @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check(capFlag == 1'b1, "R9 capture beats clear", int'(capFlag), 1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 capture value taken", expQ.size(), 0);

    // R10 quiet pin holds capValue
    begin
      logic [15:0] held;
      held = capValue;
      repeat (20) @(negedge clk);
      check(capValue == held, "R10 hold while quiet", int'(capValue), int'(held));
    end

    capPin = 1'b0;
    expQ.push_back(cnt + 16'd2);
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R4 final falling edge", expQ.size(), 0);
    finishRun();
  end
endmodule